// File: doc/BRIEF.md
# Two-Pass Subranging Conversion Sequencer

This block drives a subranging analog-to-digital front end that owns a single 4-bit flash quantiser. One conversion uses that quantiser twice. The first pass quantises the raw input and gives the upper half of the result. That coarse code then goes to an 8-bit-accurate DAC, and the analog side subtracts the DAC output from the input. The second pass quantises this residue and gives the lower half.

The sequencer accepts a start pulse and captures the coarse code. It drives the DAC code and waits a programmable number of clocks for the DAC and the subtractor to settle. It then raises the residue-select line so that the quantiser sees the residue. It captures the fine code, assembles the 8-bit result and pulses done. The DAC, the subtraction and the quantiser are outside the block.

Top module: `subrange_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, busy, done and residue-select are 0, the DAC code is 0 and the result is 0.
- R2: A start seen in an idle cycle raises busy in the next cycle. Busy then stays high through the done cycle and falls in the cycle after it.
- R3: The quantiser code present in the first busy cycle is the coarse code. From the second busy cycle onward the DAC code equals the coarse code in bits 7:4 with bits 3:0 zero, and it holds that value until the next conversion captures a new coarse code.
- R4: Residue-select is low in the first busy cycle. It is high from the second busy cycle through the done cycle inclusive, and low again when idle.
- R5: The settle interval lasts SETTLE_CYC clocks (default 4). The fine code is the quantiser code present in the busy cycle that follows the settle interval.
- R6: The result equals the coarse code in bits 7:4 and the fine code in bits 3:0. It changes only in the done cycle and holds until the next done cycle.
- R7: Done is high for exactly one cycle, the (SETTLE_CYC+3)-th cycle after the clock edge that accepted start. A conversion therefore keeps busy high for SETTLE_CYC+3 cycles.
- R8: A start that arrives while busy is high, including during the done cycle, has no effect. A start in the first idle cycle after done is accepted.
- R9: With a quantiser that resolves input bits 7:4 when residue-select is low, and (input − DAC code) bits 3:0 when it is high, the result equals the 8-bit input for every input value from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a conversion |
| q_code | input | 4 | Code from the shared flash quantiser |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| res_sel | output | 1 | High routes the residue into the quantiser |
| dac_code | output | 8 | Code for the residue DAC |
| result | output | 8 | Assembled conversion result |

## Verification
Two pairs of events can land in the same cycle. A start can coincide with the done pulse, and the result update always coincides with done. The bench pulses start in the very cycle that done is seen, then again in the first idle cycle, and also holds start high across whole conversions. A behavioural phase model, stepped every clock, decides whether each start is ignored or accepted. The bench counts busy cycles per conversion and confirms on each done that the result equals the modelled analog input, with no stray update before it.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

    localparam int CODE_W = 4;
    localparam int RES_W  = 2 * CODE_W;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COARSE = 3'd1,
        ST_SETTLE = 3'd2,
        ST_FINE   = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] upper;
        logic [CODE_W-1:0] lower;
    } split_code_t;

    // DAC drive for a coarse code: code in the upper half, zeros below
    function automatic logic [RES_W-1:0] coarse_to_dac(input logic [CODE_W-1:0] c);
        split_code_t s;
        s.upper = c;
        s.lower = '0;
        return s;
    endfunction

    function automatic logic [RES_W-1:0] join_passes(input logic [CODE_W-1:0] hi,
                                                     input logic [CODE_W-1:0] lo);
        split_code_t s;
        s.upper = hi;
        s.lower = lo;
        return s;
    endfunction

endpackage

// File: rtl/subrange_ctrl.sv
module subrange_ctrl
    import subrange_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_t state,
    output logic       take_coarse,
    output logic       take_fine
);

    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_COARSE;
            ST_COARSE: begin
                state_d = ST_SETTLE;
                cnt_d   = '0;
            end
            ST_SETTLE: begin
                if (cnt_q == LAST) state_d = ST_FINE;
                else               cnt_d   = cnt_q + 1'b1;
            end
            ST_FINE:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state       = state_q;
    assign take_coarse = (state_q == ST_COARSE);
    assign take_fine   = (state_q == ST_FINE);

endmodule

// File: rtl/subrange_datapath.sv
module subrange_datapath
    import subrange_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_coarse,
    input  logic              take_fine,
    input  logic [CODE_W-1:0] q_code,
    output logic [RES_W-1:0]  dac_code,
    output logic [RES_W-1:0]  result
);

    logic [CODE_W-1:0] coarse_q;
    logic [RES_W-1:0]  dac_q;
    logic [RES_W-1:0]  res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q <= '0;
            dac_q    <= '0;
            res_q    <= '0;
        end else begin
            if (take_coarse) begin
                coarse_q <= q_code;
                dac_q    <= coarse_to_dac(q_code);
            end
            if (take_fine) begin
                res_q <= join_passes(coarse_q, q_code);
            end
        end
    end

    assign dac_code = dac_q;
    assign result   = res_q;

endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
    import subrange_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] q_code,
    output logic              busy,
    output logic              done,
    output logic              res_sel,
    output logic [RES_W-1:0]  dac_code,
    output logic [RES_W-1:0]  result
);

    seq_state_t state;
    logic       take_coarse;
    logic       take_fine;

    subrange_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .state       (state),
        .take_coarse (take_coarse),
        .take_fine   (take_fine)
    );

    subrange_datapath u_dp (
        .clk         (clk),
        .rst         (rst),
        .take_coarse (take_coarse),
        .take_fine   (take_fine),
        .q_code      (q_code),
        .dac_code    (dac_code),
        .result      (result)
    );

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign res_sel = (state == ST_SETTLE) || (state == ST_FINE) || (state == ST_DONE);

endmodule

// File: rtl/subrange_chk.sv
module subrange_chk
    import subrange_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             res_sel,
    input logic [RES_W-1:0] dac_code,
    input logic [RES_W-1:0] result
);

    assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_busy_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    assert_dac_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (res_sel && $past(res_sel)) |-> $stable(dac_code));

    assert_sel_in_done_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && res_sel));

    assert_result_only_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind subrange_seq subrange_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .res_sel  (res_sel),
    .dac_code (dac_code),
    .result   (result)
);

// File: tb/subrange_seq_tb.sv
module subrange_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int CONV_LEN   = SETTLE + 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] q_code;
    logic       busy, done, res_sel;
    logic [7:0] dac_code, result;
    logic [7:0] ana = 8'd0;
    logic [7:0] diff;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural quantiser: raw upper bits or residue lower bits
    assign diff   = ana - dac_code;
    assign q_code = res_sel ? diff[3:0] : ana[7:4];

    subrange_seq #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .q_code(q_code),
        .busy(busy), .done(done), .res_sel(res_sel),
        .dac_code(dac_code), .result(result)
    );

    // Reference model: phase 0 idle, 1 coarse, 2..SETTLE+1 settle, SETTLE+2 fine, SETTLE+3 done
    int         ph = 0;
    logic [3:0] m_coarse = 4'd0;
    logic [7:0] m_dac = 8'd0;
    logic [7:0] m_res = 8'd0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            ph <= 0; m_coarse <= 4'd0; m_dac <= 8'd0; m_res <= 8'd0;
        end else if (ph == 0) begin
            if (start) ph <= 1;
        end else begin
            if (ph == 1) begin
                m_coarse <= q_code;
                m_dac    <= {q_code, 4'd0};
            end
            if (ph == SETTLE + 2) m_res <= {m_coarse, q_code};
            ph <= (ph == CONV_LEN) ? 0 : ph + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy    == (ph != 0),       "R2 busy",    busy,    ph != 0);
            chk(done    == (ph == CONV_LEN),"R7 done",    done,    ph == CONV_LEN);
            chk(res_sel == (ph >= 2),       "R4 res_sel", res_sel, ph >= 2);
            chk(dac_code == m_dac,          "R3 dac",     dac_code, m_dac);
            chk(result  == m_res,           "R6 R5 result", result, m_res);
        end
    end

    // Run one conversion; extra=1 pulses start mid-run and in the done cycle (R8)
    task automatic convert(input logic [7:0] v, input bit extra);
        int n = 0;
        @(negedge clk);
        ana = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 50) begin
            n++;
            if (extra && n == 3) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        n++;
        chk(n == CONV_LEN, "R7 busy length", n, CONV_LEN);
        chk(result == v, "R9 result vs input", result, v);
        if (extra) begin
            start = 1'b1;            // ignored: done cycle (R8)
            @(negedge clk);
            chk(!busy, "R8 start in done ignored", busy, 0);
            start = 1'b1;            // accepted: idle
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R8 start after done accepted", busy, 1);
            while (busy) @(negedge clk);
            chk(result == v, "R9 repeat result", result, v);
        end else begin
            start = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !res_sel, "R1 control in reset", {busy, done, res_sel}, 0);
        chk(dac_code == 8'd0 && result == 8'd0, "R1 data in reset", {dac_code, result}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && dac_code == 8'd0 && result == 8'd0, "R1 after reset", {busy, dac_code}, 0);

        convert(8'h00, 1'b0);
        convert(8'hFF, 1'b0);
        convert(8'hA5, 1'b1);
        convert(8'h5A, 1'b1);
        convert(8'h0F, 1'b0);
        convert(8'hF0, 1'b0);

        // start held high: back-to-back conversions (R8)
        @(negedge clk);
        ana = 8'h3C; start = 1'b1;
        repeat (3 * (CONV_LEN + 1)) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        chk(result == 8'h3C, "R8 R9 held start result", result, 8'h3C);

        for (int v = 0; v < 256; v++) convert(8'(v), 1'b0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule